// File: doc/BRIEF.md
# Three-Channel Split-Period PWM Generator

This block drives the six switches of a three-phase power stage from a single shared 12-bit time base. Each of the three channels has two halves, A and B. One full PWM period is made of two sub-cycles: during sub-cycle A only the A outputs may be high, and during sub-cycle B only the B outputs may be high. Each half has its own pair of compare values, so all six duty cycles are set independently.

A global mode selects how the time base moves. In ramp mode it counts from zero to the top value once for sub-cycle A and once more for sub-cycle B. In centered mode it counts up to the top value for sub-cycle A and back down to zero for sub-cycle B. Software writes the top value and the compare values into staging registers. While running, the staged values and the mode input become active only when sub-cycle B finishes, so a period never mixes old and new settings. Each channel has an asynchronous fault input that, once synchronized, forces that channel's outputs low and sets a sticky flag that software must clear.

Top module: `pwm3_stage`

## Requirements
- R1: While reset is held low at a rising edge, the counter, the sub-cycle indicator, every output and every fault flag are 0 after that edge, and all staged and active settings are 0.
- R2: While `run_en` is low, the counter is held at 0 in sub-cycle A (`sub_b` = 0) and all six outputs are low.
- R3: In ramp mode (`centered` = 0 when the period starts), sub-cycle A counts 0 up to top, then the counter returns to 0 with `sub_b` = 1 and counts 0 up to top again; after top in sub-cycle B the next period starts at 0 in sub-cycle A.
- R4: In centered mode (`centered` = 1 when the period starts), sub-cycle A counts 0 up to top; the next cycle stays at top with `sub_b` = 1, then counts down one per cycle; after 0 in sub-cycle B the next period starts at 0 in sub-cycle A.
- R5: Output A of channel n is high exactly when `run_en` = 1, `sub_b` = 0, start_A ≤ counter < end_A and the channel is not blanked; output B likewise with `sub_b` = 1 and its own start_B/end_B.
- R6: Register map: address 0 is top; address 1+4n+k holds channel n's A start (k=0), A end (k=1), B start (k=2), B end (k=3); addresses 13 to 15 are ignored. While running, written values and the `centered` input become active only at the clock edge that ends sub-cycle B.
- R7: While `run_en` is low, staged values and the `centered` input are copied to the active set on every clock edge, so a run started two cycles after a write uses it from the first cycle.
- R8: A channel's outputs are blanked from the second rising edge after its fault input rises until the second rising edge after it falls; other channels are unaffected.
- R9: A channel's fault flag is set while its synchronized fault is high, stays set after the fault goes away, and is cleared by `fault_clr` only when the synchronized fault is low.
- R10: The counter never exceeds the active top value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Run enable; low holds the time base at 0 |
| centered | input | 1 | Mode request: 1 centered, 0 ramp; applied at period start |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Register write data |
| fault_in | input | 3 | Asynchronous per-channel fault inputs, active high |
| fault_clr | input | 3 | Per-channel sticky flag clear |
| pwm_a | output | 3 | Half A output per channel |
| pwm_b | output | 3 | Half B output per channel |
| fault_flag | output | 3 | Sticky per-channel fault flag |
| cnt | output | 12 | Time base value |
| sub_b | output | 1 | 1 during sub-cycle B |

## Verification
The hardest situation to reach is a register write, a mode change or a fault edge that lands in the middle of a period while the time base sits right at a turnaround point, such as top in sub-cycle A of centered mode or 0 in sub-cycle B. The stimulus keeps the top value small (0 to 12) so turnarounds come every few cycles, and writes random addresses, toggles the mode request and pulses faults and clears at random against a cycle-accurate bench model, so mid-period writes and boundary collisions occur thousands of times. A few directed steps cover reset, a held idle state and a run started right after a write.

// File: rtl/pwm3_pkg.sv
// Shared definitions for the three-channel split-period PWM generator.
// Assumes: all modules agree on the counter width and register layout below.
package pwm3_pkg;
    localparam int CNT_W   = 12;
    localparam int NCH     = 3;
    localparam int HALVES  = 2;
    localparam int NREG    = 1 + 2 * HALVES * NCH;
    localparam int ADDR_W  = $clog2(NREG);

    typedef enum logic {
        MODE_RAMP   = 1'b0,
        MODE_CENTER = 1'b1
    } cnt_mode_e;

    // Register index of a compare value: channel, half (0=A,1=B), edge (0=start,1=end)
    function automatic int cmp_idx(input int ch, input int half, input int edge_sel);
        return 1 + 2 * HALVES * ch + 2 * half + edge_sel;
    endfunction
endpackage

// File: rtl/pwm3_timebase.sv
// Shared time base: counts in ramp or centered mode and marks sub-cycles.
// Assumes: top_act only changes on a cycle where load_o is high.
module pwm3_timebase
    import pwm3_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         mode_req,
    input  logic [W-1:0] top_act,
    output logic [W-1:0] cnt_o,
    output logic         sub_b_o,
    output logic         load_o
);
    cnt_mode_e mode_q;
    logic      at_top;
    logic      at_zero;
    logic      period_end;

    // Decode the turnaround points of the current period
    always_comb begin
        at_top     = (cnt_o == top_act);
        at_zero    = (cnt_o == '0);
        period_end = run_en && sub_b_o && ((mode_q == MODE_CENTER) ? at_zero : at_top);
        load_o     = !run_en || period_end;
    end

    // Advance the counter and sub-cycle state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o   <= '0;
            sub_b_o <= 1'b0;
            mode_q  <= MODE_RAMP;
        end else if (load_o) begin
            cnt_o   <= '0;
            sub_b_o <= 1'b0;
            mode_q  <= cnt_mode_e'(mode_req);
        end else if (mode_q == MODE_RAMP) begin
            if (at_top) begin
                cnt_o   <= '0;
                sub_b_o <= 1'b1;
            end else begin
                cnt_o   <= cnt_o + 1'b1;
            end
        end else if (!sub_b_o) begin
            if (at_top) begin
                sub_b_o <= 1'b1;
            end else begin
                cnt_o   <= cnt_o + 1'b1;
            end
        end else begin
            cnt_o <= cnt_o - 1'b1;
        end
    end

    a_r10_cnt_le_top: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= top_act);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt_o == '0) && !sub_b_o);

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && mode_q == MODE_RAMP && !sub_b_o && at_top) |=> (cnt_o == '0));

    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && mode_q == MODE_CENTER && sub_b_o && !at_zero)
            |=> (cnt_o == $past(cnt_o) - 1'b1) || (cnt_o == '0));
endmodule

// File: rtl/pwm3_regbank.sv
// Staging and active copies of the top and compare values.
// Assumes: load is driven by the time base at period end or while idle.
module pwm3_regbank
    import pwm3_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int NR = NREG,
    parameter int AW = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [W-1:0]       wr_data,
    input  logic               load,
    output logic [NR-1:0][W-1:0] act_q
);
    logic [NR-1:0][W-1:0] stg_q;

    generate
        for (genvar i = 0; i < NR; i++) begin : g_reg
            // Capture software writes into the staging copy
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_q[i] <= '0;
                end else if (wr_en && (wr_addr == AW'(i))) begin
                    stg_q[i] <= wr_data;
                end
            end

            // Transfer the staging copy to the active copy at a period boundary
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    act_q[i] <= '0;
                end else if (load) begin
                    act_q[i] <= stg_q[i];
                end
            end
        end
    endgenerate

    a_r6_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_q));
endmodule

// File: rtl/pwm3_fault.sv
// Per-channel fault synchronizer and sticky flag.
// Assumes: fault_in is asynchronous; clear is a synchronous request.
module pwm3_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    input  logic clr,
    output logic blank,
    output logic flag
);
    logic s1_q;

    // Two-flop synchronizer for the asynchronous fault input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q  <= 1'b0;
            blank <= 1'b0;
        end else begin
            s1_q  <= fault_in;
            blank <= s1_q;
        end
    end

    // Sticky flag: set by a live fault, cleared by request once the fault is gone
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (blank) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> flag);
endmodule

// File: rtl/pwm3_half.sv
// One waveform half: high inside its compare window during its own sub-cycle.
// Assumes: cnt and the compare values come from registers; output is combinational.
module pwm3_half
    import pwm3_pkg::*;
#(
    parameter int W = CNT_W,
    parameter bit HALF_B = 1'b0
) (
    input  logic         run_en,
    input  logic         sub_b,
    input  logic         blank,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_start,
    input  logic [W-1:0] cmp_end,
    output logic         out
);
    logic own_phase;
    logic in_window;

    // Window compare gated by phase, run and fault blanking
    always_comb begin
        own_phase = (sub_b == HALF_B);
        in_window = (cnt >= cmp_start) && (cnt < cmp_end);
        out       = run_en && own_phase && in_window && !blank;
    end
endmodule

// File: rtl/pwm3_stage.sv
// Top: three-channel split-period PWM generator with staged settings and fault blanking.
// Assumes: a single clock; fault inputs may be asynchronous to it.
module pwm3_stage
    import pwm3_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int NC = NCH,
    localparam int NR = 1 + 2 * HALVES * NC,
    localparam int AW = $clog2(NR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          centered,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [NC-1:0] fault_in,
    input  logic [NC-1:0] fault_clr,
    output logic [NC-1:0] pwm_a,
    output logic [NC-1:0] pwm_b,
    output logic [NC-1:0] fault_flag,
    output logic [W-1:0]  cnt,
    output logic          sub_b
);
    logic [NR-1:0][W-1:0] act;
    logic                 load;
    logic [NC-1:0]        blank;

    pwm3_regbank #(.W(W), .NR(NR), .AW(AW)) i_regbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .act_q   (act)
    );

    pwm3_timebase #(.W(W)) i_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .mode_req (centered),
        .top_act  (act[0]),
        .cnt_o    (cnt),
        .sub_b_o  (sub_b),
        .load_o   (load)
    );

    generate
        for (genvar c = 0; c < NC; c++) begin : g_ch
            pwm3_fault i_fault (
                .clk      (clk),
                .rst_n    (rst_n),
                .fault_in (fault_in[c]),
                .clr      (fault_clr[c]),
                .blank    (blank[c]),
                .flag     (fault_flag[c])
            );

            pwm3_half #(.W(W), .HALF_B(1'b0)) i_half_a (
                .run_en    (run_en),
                .sub_b     (sub_b),
                .blank     (blank[c]),
                .cnt       (cnt),
                .cmp_start (act[1 + 4 * c]),
                .cmp_end   (act[2 + 4 * c]),
                .out       (pwm_a[c])
            );

            pwm3_half #(.W(W), .HALF_B(1'b1)) i_half_b (
                .run_en    (run_en),
                .sub_b     (sub_b),
                .blank     (blank[c]),
                .cnt       (cnt),
                .cmp_start (act[3 + 4 * c]),
                .cmp_end   (act[4 + 4 * c]),
                .out       (pwm_b[c])
            );

            a_r8_blank_outputs: assert property (@(posedge clk) disable iff (!rst_n)
                blank[c] |-> !pwm_a[c] && !pwm_b[c]);

            a_r5_halves_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
                !(pwm_a[c] && pwm_b[c]));
        end
    endgenerate
endmodule

// File: tb/test_pwm3_stage.sv
module test_pwm3_stage;
    localparam int W  = 12;
    localparam int NC = 3;
    localparam int NR = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          centered = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [NC-1:0] fault_in = '0;
    logic [NC-1:0] fault_clr = '0;
    logic [NC-1:0] pwm_a, pwm_b, fault_flag;
    logic [W-1:0]  cnt;
    logic          sub_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state
    logic [W-1:0]  m_stg [NR];
    logic [W-1:0]  m_act [NR];
    logic [W-1:0]  m_cnt;
    logic          m_sub, m_mode;
    logic [NC-1:0] m_s1, m_s2, m_flag;

    pwm3_stage i_pwm3_stage (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .centered(centered),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fault_in(fault_in), .fault_clr(fault_clr),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .fault_flag(fault_flag),
        .cnt(cnt), .sub_b(sub_b)
    );

    always #10 clk = ~clk;

    // Model update on each rising edge, from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin m_stg[i] = '0; m_act[i] = '0; end
            m_cnt = '0; m_sub = 1'b0; m_mode = 1'b0;
            m_s1 = '0; m_s2 = '0; m_flag = '0;
        end else begin
            logic pend;
            pend = run_en && m_sub && (m_mode ? (m_cnt == 0) : (m_cnt == m_act[0]));
            if (!run_en || pend) begin
                for (int i = 0; i < NR; i++) m_act[i] = m_stg[i];
                m_mode = centered; m_cnt = '0; m_sub = 1'b0;
            end else if (!m_mode) begin
                if (m_cnt == m_act[0]) begin m_cnt = '0; m_sub = 1'b1; end
                else m_cnt = m_cnt + 1;
            end else if (!m_sub) begin
                if (m_cnt == m_act[0]) m_sub = 1'b1;
                else m_cnt = m_cnt + 1;
            end else begin
                m_cnt = m_cnt - 1;
            end
            if (wr_en && wr_addr < NR) m_stg[wr_addr] = wr_data;
            for (int c = 0; c < NC; c++) begin
                if (m_s2[c]) m_flag[c] = 1'b1;
                else if (fault_clr[c]) m_flag[c] = 1'b0;
            end
            m_s2 = m_s1;
            m_s1 = fault_in;
        end
    end

    function automatic logic exp_out(input int c, input int half);
        logic [W-1:0] lo, hi;
        lo = m_act[1 + 4 * c + 2 * half];
        hi = m_act[2 + 4 * c + 2 * half];
        return run_en && (m_sub == half[0]) && (m_cnt >= lo) && (m_cnt < hi) && !m_s2[c];
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare every observable output against the model
    task automatic compare_all();
        string rq;
        logic pending;
        pending = 1'b0;
        for (int i = 0; i < NR; i++) if (m_act[i] != m_stg[i]) pending = 1'b1;
        if (!run_en) rq = "R2";
        else if (pending) rq = "R6";
        else if (m_mode) rq = "R4";
        else rq = "R3";
        check(rq, "cnt", int'(cnt), int'(m_cnt));
        check(rq, "sub_b", int'(sub_b), int'(m_sub));
        check("R10", "cnt_le_top", int'(cnt <= m_act[0]), 1);
        for (int c = 0; c < NC; c++) begin
            string ro;
            ro = m_s2[c] ? "R8" : "R5";
            check(ro, $sformatf("pwm_a[%0d]", c), int'(pwm_a[c]), int'(exp_out(c, 0)));
            check(ro, $sformatf("pwm_b[%0d]", c), int'(pwm_b[c]), int'(exp_out(c, 1)));
        end
        check("R9", "fault_flag", int'(fault_flag), int'(m_flag));
    endtask

    task automatic write_reg(input int a, input int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = W'(d);
        @(negedge clk); compare_all();
        wr_en = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "cnt", int'(cnt), 0);
        check("R1", "sub_b", int'(sub_b), 0);
        check("R1", "pwm", int'({pwm_a, pwm_b}), 0);
        check("R1", "fault_flag", int'(fault_flag), 0);
        rst_n = 1'b1;
        @(negedge clk); compare_all();

        // R7: configure while idle, then start
        write_reg(0, 3);
        write_reg(1, 1); write_reg(2, 3);
        write_reg(15, 7);
        @(negedge clk); compare_all();
        run_en = 1'b1;
        repeat (4) begin @(negedge clk); compare_all(); end
        check("R7", "cnt after first sub-cycle A", int'(cnt), 0);
        check("R7", "sub_b after first sub-cycle A", int'(sub_b), 1);

        // Random phases: ramp, centered, faults, run toggling
        for (int ph = 0; ph < 6; ph++) begin
            for (int cyc = 0; cyc < 3000; cyc++) begin
                @(negedge clk);
                compare_all();
                wr_en = ($urandom_range(0, 7) == 0);
                wr_addr = 4'($urandom_range(0, 15));
                wr_data = W'(wr_addr == 0 ? $urandom_range(0, 12) : $urandom_range(0, 14));
                if ($urandom_range(0, 40) == 0) centered = (ph % 2 == 1) ? ~centered : 1'b0;
                if (ph % 2 == 1 && $urandom_range(0, 200) == 0) centered = 1'b1;
                if (ph >= 2 && $urandom_range(0, 30) == 0) fault_in = NC'($urandom_range(0, 7));
                if (ph < 2) fault_in = '0;
                fault_clr = (ph >= 2) ? NC'($urandom_range(0, 7)) : '0;
                if (ph >= 4 && $urandom_range(0, 60) == 0) run_en = ~run_en;
                if (ph < 4) run_en = 1'b1;
            end
        end

        // R9 directed: flag persists after fault removed, cleared afterwards
        wr_en = 1'b0; fault_clr = '0; fault_in = 3'b010;
        repeat (3) begin @(negedge clk); compare_all(); end
        fault_in = '0;
        repeat (3) begin @(negedge clk); compare_all(); end
        check("R9", "flag held after fault gone", int'(fault_flag[1]), 1);
        fault_clr = 3'b010;
        @(negedge clk); compare_all();
        fault_clr = '0;
        check("R9", "flag cleared", int'(fault_flag[1]), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule